// File: doc/BRIEF.md
# Serial Command Packet Bus Master

This block sits behind a byte-level serial receiver and turns framed command packets into accesses on a simple 16-bit register bus. Each packet carries a start byte, a rolling sequence number, an operation code, a length byte, a little-endian address, a little-endian data word for writes only, and a closing 8-bit additive checksum. The block parses the byte stream and validates the packet. It then issues exactly one bus write or one bus read.

For a read, the returned word goes back to a byte-level serial transmitter as two bytes, low byte first. The block waits for the transmitter to report completion of each byte before it offers the next one. A packet that is malformed in any way produces no bus activity, and the parser goes back to searching for a start byte. The serial bit framing itself belongs to the transmitter and receiver and is outside this block.

Top module: `pkt_bus_master`

## Requirements
- R1: While searching for a packet, any received byte other than the start value 0xAA is discarded and causes no bus access.
- R2: A write packet has the bytes 0xAA, sequence number, opcode 0x03, length 0x04, address low, address high, data low, data high and checksum. When it is accepted, `bus_wr` is high for exactly one cycle, in the cycle after the checksum byte is taken. `bus_addr` and `bus_wdata` carry the packet's address and data in that cycle.
- R3: A read packet has the bytes 0xAA, sequence number, opcode 0x04, length 0x02, address low, address high and checksum. When it is accepted, `bus_rd` is high for exactly one cycle, in the cycle after the checksum byte, with `bus_addr` set to the packet address.
- R4: The checksum byte must equal the sum modulo 256 of every earlier byte of the packet, the start byte included. On a mismatch the packet causes no bus access.
- R5: An opcode other than 0x03 or 0x04 drops the packet with no bus access. The next packet is then parsed normally.
- R6: A length byte that does not match the opcode (4 for a write, 2 for a read) drops the packet with no bus access.
- R7: The read word is sampled from `bus_rdata` at the end of the cycle that follows the `bus_rd` cycle. It is returned as a one-cycle `tx_req` carrying the low byte, then, only after a `tx_done` pulse, a one-cycle `tx_req` carrying the high byte. A second `tx_done` ends the reply.
- R8: Bytes that arrive between a read strobe and the final `tx_done` of its reply are discarded.
- R9: `bus_wr` and `bus_rd` are each at most one cycle wide and are never high in the same cycle.
- R10: The sequence number is not checked against an expected value. It only enters the checksum, so packets numbered 0xFF and then 0x00 are both accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_byte | input | 8 | Received byte |
| bus_addr | output | 16 | Register bus address |
| bus_wdata | output | 16 | Register bus write data |
| bus_wr | output | 1 | One-cycle write strobe |
| bus_rd | output | 1 | One-cycle read strobe |
| bus_rdata | input | 16 | Register bus read data, valid the cycle after `bus_rd` |
| tx_req | output | 1 | One-cycle request to send `tx_byte` |
| tx_byte | output | 8 | Byte to transmit |
| tx_done | input | 1 | Transmitter finished the last requested byte |

## Verification
Well-formed writes and reads are sent, with the strobe cycle checked directly after the checksum byte. This separates correct decoding from off-by-one timing. Packets are also sent with a wrong checksum, an unknown opcode and a mismatched length, each followed by a good packet, which shows that every drop returns the parser to searching and does not stall it. Leading junk bytes and a full packet sent during a pending reply show which bytes are discarded. The read data bus changes value around the capture cycle and the transmitter answers late, which distinguishes the correct sampling cycle and byte order from a reply that does not wait for completion.

// File: rtl/pkt_pkg.sv
package pkt_pkg;
  localparam logic [7:0] START_BYTE = 8'hAA;
  localparam logic [7:0] OP_WRITE   = 8'h03;
  localparam logic [7:0] OP_READ    = 8'h04;
  localparam logic [7:0] LEN_WRITE  = 8'h04;
  localparam logic [7:0] LEN_READ   = 8'h02;

  typedef enum logic [3:0] {
    PS_HUNT, PS_SEQ, PS_OP, PS_LEN, PS_ALO, PS_AHI, PS_DLO, PS_DHI, PS_SUM
  } parse_st_t;

  typedef enum logic [1:0] {RS_IDLE, RS_SEND, RS_WAIT} reply_st_t;

  // running additive checksum, modulo 256
  function automatic logic [7:0] csum_step(input logic [7:0] acc, input logic [7:0] b);
    return acc + b;
  endfunction

  function automatic logic op_known(input logic [7:0] op);
    return (op == OP_WRITE) || (op == OP_READ);
  endfunction

  function automatic logic [7:0] op_length(input logic [7:0] op);
    return (op == OP_WRITE) ? LEN_WRITE : LEN_READ;
  endfunction
endpackage

// File: rtl/pkt_parser.sv
module pkt_parser
  import pkt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              fire,
  output logic              fire_wr,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata
);
  parse_st_t  st;
  logic [7:0] acc;
  logic [7:0] op;
  logic       take;

  assign take = rx_valid && !hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= PS_HUNT;
      acc     <= '0;
      op      <= '0;
      fire    <= 1'b0;
      fire_wr <= 1'b0;
      addr    <= '0;
      wdata   <= '0;
    end else begin
      fire <= 1'b0;
      if (take) begin
        if (st != PS_HUNT && st != PS_SUM) acc <= csum_step(acc, rx_byte);
        case (st)
          PS_HUNT: if (rx_byte == START_BYTE) begin
            acc <= rx_byte;
            st  <= PS_SEQ;
          end
          PS_SEQ: st <= PS_OP;
          PS_OP: begin
            op <= rx_byte;
            st <= op_known(rx_byte) ? PS_LEN : PS_HUNT;
          end
          PS_LEN: st <= (rx_byte == op_length(op)) ? PS_ALO : PS_HUNT;
          PS_ALO: begin addr[7:0] <= rx_byte; st <= PS_AHI; end
          PS_AHI: begin
            addr[ADDR_W-1:8] <= rx_byte[ADDR_W-9:0];
            st <= (op == OP_WRITE) ? PS_DLO : PS_SUM;
          end
          PS_DLO: begin wdata[7:0] <= rx_byte; st <= PS_DHI; end
          PS_DHI: begin wdata[DATA_W-1:8] <= rx_byte[DATA_W-9:0]; st <= PS_SUM; end
          PS_SUM: begin
            if (rx_byte == acc) begin
              fire    <= 1'b1;
              fire_wr <= (op == OP_WRITE);
            end
            st <= PS_HUNT;
          end
          default: st <= PS_HUNT;
        endcase
      end
    end
  end

  // R2 / R3: an accepted packet fires only right after a received byte
  p_fire_after_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $past(rx_valid));
  // R4: a packet can only be accepted from the checksum state
  p_fire_from_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $past(st) == PS_SUM);
endmodule

// File: rtl/pkt_reply.sv
module pkt_reply
  import pkt_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] word,
  input  logic              tx_done,
  output logic              tx_req,
  output logic [7:0]        tx_byte,
  output logic              busy
);
  localparam int NBYTES = DATA_W / 8;
  localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  reply_st_t         st;
  logic [DATA_W-1:0] word_q;
  logic [IDX_W-1:0]  idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= RS_IDLE;
      word_q <= '0;
      idx    <= '0;
    end else begin
      case (st)
        RS_IDLE: if (load) begin
          word_q <= word;
          idx    <= '0;
          st     <= RS_SEND;
        end
        RS_SEND: st <= RS_WAIT;
        RS_WAIT: if (tx_done) begin
          if (idx == IDX_W'(NBYTES - 1)) st <= RS_IDLE;
          else begin
            idx <= idx + 1'b1;
            st  <= RS_SEND;
          end
        end
        default: st <= RS_IDLE;
      endcase
    end
  end

  assign tx_req  = (st == RS_SEND);
  assign tx_byte = 8'(word_q >> (8 * idx));
  assign busy    = (st != RS_IDLE);

  // R7: no new byte is offered until the transmitter reports done
  p_wait_for_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RS_WAIT && !tx_done) |=> !tx_req);
  p_req_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |=> !tx_req);
endmodule

// File: rtl/pkt_bus_master.sv
module pkt_bus_master
  import pkt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_wr,
  output logic              bus_rd,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              tx_req,
  output logic [7:0]        tx_byte,
  input  logic              tx_done
);
  logic fire, fire_wr;
  logic rd_wait;
  logic reply_busy;
  logic hold;

  assign hold = bus_rd || rd_wait || reply_busy;

  pkt_parser #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_parser (
    .clk(clk), .rst_n(rst_n), .hold(hold),
    .rx_valid(rx_valid), .rx_byte(rx_byte),
    .fire(fire), .fire_wr(fire_wr),
    .addr(bus_addr), .wdata(bus_wdata)
  );

  assign bus_wr = fire && fire_wr;
  assign bus_rd = fire && !fire_wr;

  // read data is valid on the cycle after the strobe
  always_ff @(posedge clk) begin
    if (!rst_n) rd_wait <= 1'b0;
    else        rd_wait <= bus_rd;
  end

  pkt_reply #(.DATA_W(DATA_W)) u_reply (
    .clk(clk), .rst_n(rst_n),
    .load(rd_wait), .word(bus_rdata),
    .tx_done(tx_done), .tx_req(tx_req), .tx_byte(tx_byte),
    .busy(reply_busy)
  );

  p_wr_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> !bus_wr);
  p_rd_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> !bus_rd);
  p_no_access_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reply_busy |-> !(bus_wr || bus_rd));
  p_reply_follows_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reply_busy) |-> $past(rd_wait));
endmodule

// File: tb/tb_pkt_bus_master.sv
`timescale 1ns/1ps
module tb_pkt_bus_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic [15:0] bus_addr, bus_wdata, bus_rdata = 16'hDEAD;
  logic        bus_wr, bus_rd, tx_req, tx_done = 1'b0;
  logic [7:0]  tx_byte;

  int checks = 0, errors = 0;
  int wr_cnt = 0, rd_cnt = 0, tx_cnt = 0;
  logic [15:0] wr_addr, wr_data, rd_addr;
  logic [7:0]  tx_log [0:15];
  logic        last_wr, last_rd;

  always #5 clk = ~clk;

  pkt_bus_master dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .tx_req(tx_req), .tx_byte(tx_byte), .tx_done(tx_done)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_wr) begin wr_cnt++; wr_addr = bus_addr; wr_data = bus_wdata; end
      if (bus_rd) begin rd_cnt++; rd_addr = bus_addr; end
      if (tx_req) begin tx_log[tx_cnt % 16] = tx_byte; tx_cnt++; end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
    last_wr = bus_wr; last_rd = bus_rd;
    @(negedge clk);
  endtask

  // builds a packet; len_override < 0 means use the right length
  task automatic send_pkt(input logic [7:0] seq, input logic [7:0] op, input int len_override,
                          input logic [15:0] addr, input logic [15:0] data, input int sum_delta);
    logic [7:0] pk [0:9];
    int n = 0, total = 0;
    bit has_data = (op == 8'h03);
    pk[n++] = 8'hAA; pk[n++] = seq; pk[n++] = op;
    pk[n++] = (len_override >= 0) ? 8'(len_override) : (has_data ? 8'd4 : 8'd2);
    pk[n++] = addr[7:0]; pk[n++] = addr[15:8];
    if (has_data) begin pk[n++] = data[7:0]; pk[n++] = data[15:8]; end
    for (int i = 0; i < n; i++) total += pk[i];
    pk[n++] = 8'((total + sum_delta) % 256);
    for (int i = 0; i < n; i++) send_byte(pk[i]);
  endtask

  task automatic pulse_done();
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
  endtask

  task automatic wait_tx(input int target);
    for (int i = 0; i < 50 && tx_cnt < target; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(bus_wr == 0, "R9 reset wr", bus_wr, 0);
    chk(bus_rd == 0, "R9 reset rd", bus_rd, 0);
    chk(tx_req == 0, "R7 reset tx_req", tx_req, 0);
  endtask

  task automatic t_write();
    int w0 = wr_cnt;
    send_pkt(8'h01, 8'h03, -1, 16'h1234, 16'hBEEF, 0);
    chk(last_wr == 1, "R2 strobe cycle after checksum", last_wr, 1);
    chk(wr_cnt == w0 + 1, "R2 one write (R9 width)", wr_cnt - w0, 1);
    chk(wr_addr == 16'h1234, "R2 address", wr_addr, 16'h1234);
    chk(wr_data == 16'hBEEF, "R2 data", wr_data, 16'hBEEF);
  endtask

  task automatic t_junk();
    int w0 = wr_cnt;
    send_byte(8'h12); send_byte(8'h55); send_byte(8'h00);
    chk(wr_cnt == w0 && rd_cnt >= 0, "R1 junk no access", wr_cnt - w0, 0);
    send_pkt(8'h02, 8'h03, -1, 16'h0042, 16'h0007, 0);
    chk(wr_cnt == w0 + 1 && wr_data == 16'h0007, "R1 packet after junk", wr_cnt - w0, 1);
  endtask

  task automatic t_bad(input string req, input logic [7:0] op, input int len, input int dsum);
    int w0 = wr_cnt, r0 = rd_cnt;
    send_pkt(8'h03, op, len, 16'h0506, 16'h0708, dsum);
    chk(wr_cnt == w0 && rd_cnt == r0, req, wr_cnt + rd_cnt - w0 - r0, 0);
    send_pkt(8'h04, 8'h03, -1, 16'h0C0D, 16'h1357, 0);
    chk(wr_cnt == w0 + 1 && wr_addr == 16'h0C0D, {req, " recovery"}, wr_cnt - w0, 1);
  endtask

  task automatic t_read(input logic [15:0] addr, input logic [15:0] word, input bit intrude);
    int r0 = rd_cnt, w0 = wr_cnt, t0 = tx_cnt;
    bus_rdata = 16'hDEAD;
    send_pkt(8'h05, 8'h04, -1, addr, 16'h0000, 0);
    chk(last_rd == 1, "R3 strobe cycle after checksum", last_rd, 1);
    chk(rd_cnt == r0 + 1 && rd_addr == addr, "R3 read address", rd_addr, addr);
    chk(!(last_wr && last_rd), "R9 exclusive strobes", last_wr, 0);
    // strobe seen at the negedge inside send_byte, followed by one more negedge:
    // data must be valid in the cycle after the strobe only
    bus_rdata = word;
    @(negedge clk); bus_rdata = 16'hDEAD;
    wait_tx(t0 + 1);
    chk(tx_cnt == t0 + 1 && tx_log[t0 % 16] == word[7:0], "R7 low byte first",
        tx_log[t0 % 16], word[7:0]);
    if (intrude) begin
      send_pkt(8'h06, 8'h03, -1, 16'h7777, 16'h8888, 0);
      chk(wr_cnt == w0, "R8 bytes ignored during reply", wr_cnt - w0, 0);
    end else repeat (6) @(negedge clk);
    chk(tx_cnt == t0 + 1, "R7 waits for done", tx_cnt - t0, 1);
    pulse_done();
    wait_tx(t0 + 2);
    chk(tx_cnt == t0 + 2 && tx_log[(t0 + 1) % 16] == word[15:8], "R7 high byte second",
        tx_log[(t0 + 1) % 16], word[15:8]);
    pulse_done();
    repeat (4) @(negedge clk);
    chk(tx_cnt == t0 + 2, "R7 exactly two bytes", tx_cnt - t0, 2);
  endtask

  task automatic t_seq_wrap();
    int w0 = wr_cnt;
    send_pkt(8'hFF, 8'h03, -1, 16'h0101, 16'h0202, 0);
    send_pkt(8'h00, 8'h03, -1, 16'h0303, 16'h0404, 0);
    chk(wr_cnt == w0 + 2 && wr_data == 16'h0404, "R10 sequence wrap accepted", wr_cnt - w0, 2);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_junk();
    t_bad("R4 bad checksum", 8'h03, -1, 1);
    t_bad("R5 unknown opcode", 8'h05, 2, 0);
    t_bad("R6 length mismatch", 8'h03, 2, 0);
    t_bad("R6 read with write length", 8'h04, 4, 0);
    t_read(16'h0A0B, 16'hC3E1, 1'b0);
    t_read(16'hFFFF, 16'h5A01, 1'b1);
    t_write();
    t_seq_wrap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule